// File: doc/BRIEF.md
# Pixel PLL Reprogramming Sequencer

This block retunes a pixel-clock PLL without letting the PLL run on a half-written divider. On a start strobe it captures a 32-bit target setting. It reads the PLL control register once, then issues a fixed chain of five writes to that register. The writes park the PLL in reset and bypass, merge in the new divider, wait for the loop control voltage to settle, enable the PLL, and finally release reset and then bypass.

Each write builds on the image left by the one before. The control bits inside the supplied setting are masked off, so a caller cannot skip or reorder the protective steps. The settle wait is a down-counter of `CLK_HZ/1000` cycles, which is roughly one millisecond at the system clock.

The controller is a state machine with eight states:
- `S_IDLE` waits for `start_i`.
- `S_FETCH` holds the read request until the read data is valid.
- `S_ARM` writes step 1 and moves on when the write is accepted.
- `S_LOAD` writes step 2 and moves on when the write is accepted.
- `S_SETTLE` waits until the counter expires.
- `S_ENABLE` writes step 3.
- `S_UNRESET` writes step 4.
- `S_UNBYPASS` writes step 5 and returns to `S_IDLE` when the write is accepted.

Top module: `pll_reload_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `rd_req_o` and `wr_en_o` are all low.
- R2: A start in `S_IDLE` raises `rd_req_o`, which stays high until `rd_valid_i`. Exactly one register read happens per sequence, and it comes before any write.
- R3: The first write is the read value with bit 5 cleared and with bit 31 (reset) and bit 8 (bypass) set.
- R4: The second write is the first write ORed with the setting captured at start, after bits 31, 11, 8 and 5 of that setting are cleared (mask 0x80000920). Changes on `setting_i` after the start cycle have no effect.
- R5: Between acceptance of the second write and the request for the third, `wr_en_o` is low for exactly `CLK_HZ/1000` cycles (at least 1). No other pair of writes has a gap between them.
- R6: The third write is the second write with bit 11 (enable) set.
- R7: The fourth write is the third with bit 31 cleared. The fifth write is the fourth with bit 8 cleared. The five writes come in this order.
- R8: While `wr_en_o` is high and `wr_ready_i` is low, the request and `wr_data_o` hold their values.
- R9: `busy_o` is high from the cycle after start until the fifth write is accepted. `done_o` is then high for exactly one cycle, with `busy_o` low.
- R10: A start while busy is ignored. It causes no extra read, no extra write and no restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a reprogramming sequence (accepted only when idle) |
| setting_i | input | 32 | New PLL divider setting, captured on start |
| rd_req_o | output | 1 | Read request for the PLL control register |
| rd_data_i | input | 32 | Current control register value |
| rd_valid_i | input | 1 | Read data valid, completes the read |
| wr_en_o | output | 1 | Write request for the PLL control register |
| wr_data_o | output | 32 | Value to write |
| wr_ready_i | input | 1 | Write accepted when high together with `wr_en_o` |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when the last write is accepted |

## Verification
The assertions assume the register side answers each request in bounded time. They also assume that `rd_valid_i` only matters while a read is requested and that `wr_ready_i` may stall a write for any number of cycles. The bench keeps to this: it models the register as a variable that answers reads after a chosen latency and accepts writes either at once or on alternating cycles. It pulses start only when idle, except for one deliberate pulse during the settle wait. It changes `setting_i` after each start so that the capture is exercised.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    localparam int REG_W   = 32;

    // Control bit positions inside the PLL control register
    localparam int BIT_RST = 31;   // loop reset
    localparam int BIT_BYP = 8;    // bypass
    localparam int BIT_EN  = 11;   // enable
    localparam int BIT_AUX = 5;    // cleared while arming

    localparam logic [REG_W-1:0] ONE_W   = {{(REG_W-1){1'b0}}, 1'b1};
    localparam logic [REG_W-1:0] M_RST   = ONE_W << BIT_RST;
    localparam logic [REG_W-1:0] M_BYP   = ONE_W << BIT_BYP;
    localparam logic [REG_W-1:0] M_EN    = ONE_W << BIT_EN;
    localparam logic [REG_W-1:0] M_AUX   = ONE_W << BIT_AUX;
    localparam logic [REG_W-1:0] M_CTRL  = M_RST | M_BYP | M_EN | M_AUX;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_ARM,
        S_LOAD,
        S_SETTLE,
        S_ENABLE,
        S_UNRESET,
        S_UNBYPASS
    } seq_state_e;

endpackage

// File: rtl/pll_seq_settle_timer.sv
module pll_seq_settle_timer #(
    parameter int DELAY = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);
    localparam int CW = $clog2(DELAY + 1);

    logic [CW-1:0] cnt_q;
    logic          run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load_i) begin
            cnt_q <= CW'(DELAY - 1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) begin
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign expired_o = run_q && (cnt_q == '0);

    // R5: the expiry indication is a single cycle per load
    assert_expiry_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        expired_o |=> !expired_o);

    // R5: a fresh load never expires on the following cycle unless the wait is one cycle
    assert_no_early_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && DELAY > 1) |=> !expired_o);

endmodule

// File: rtl/pll_seq_image.sv
module pll_seq_image
    import pll_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_set_i,
    input  logic [REG_W-1:0] setting_i,
    input  logic             cap_rd_i,
    input  logic [REG_W-1:0] rd_data_i,
    input  logic             ld_set_i,
    input  logic             set_en_i,
    input  logic             clr_rst_i,
    input  logic             clr_byp_i,
    output logic [REG_W-1:0] image_o
);
    logic [REG_W-1:0] set_q;
    logic [REG_W-1:0] img_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_q <= '0;
        end else if (cap_set_i) begin
            set_q <= setting_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            img_q <= '0;
        end else if (cap_rd_i) begin
            img_q <= (rd_data_i & ~M_AUX) | M_RST | M_BYP;
        end else if (ld_set_i) begin
            img_q <= img_q | (set_q & ~M_CTRL);
        end else if (set_en_i) begin
            img_q <= img_q | M_EN;
        end else if (clr_rst_i) begin
            img_q <= img_q & ~M_RST;
        end else if (clr_byp_i) begin
            img_q <= img_q & ~M_BYP;
        end
    end

    assign image_o = img_q;

    // R3: once the read is captured the image holds reset and bypass
    assert_arm_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_rd_i |=> img_q[BIT_RST] && img_q[BIT_BYP] && !img_q[BIT_AUX]);

    // R7: after the last step the PLL is enabled and out of reset and bypass
    assert_final_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_byp_i |=> img_q[BIT_EN] && !img_q[BIT_RST] && !img_q[BIT_BYP]);

endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
    import pll_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic rd_valid_i,
    input  logic wr_ready_i,
    input  logic tmr_expired_i,
    output logic rd_req_o,
    output logic wr_en_o,
    output logic busy_o,
    output logic done_o,
    output logic cap_set_o,
    output logic cap_rd_o,
    output logic ld_set_o,
    output logic tmr_load_o,
    output logic set_en_o,
    output logic clr_rst_o,
    output logic clr_byp_o
);
    seq_state_e state_q, state_d;
    logic       done_q;

    // State register and done pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == S_UNBYPASS) && wr_ready_i;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (start_i)       state_d = S_FETCH;
            S_FETCH:    if (rd_valid_i)    state_d = S_ARM;
            S_ARM:      if (wr_ready_i)    state_d = S_LOAD;
            S_LOAD:     if (wr_ready_i)    state_d = S_SETTLE;
            S_SETTLE:   if (tmr_expired_i) state_d = S_ENABLE;
            S_ENABLE:   if (wr_ready_i)    state_d = S_UNRESET;
            S_UNRESET:  if (wr_ready_i)    state_d = S_UNBYPASS;
            S_UNBYPASS: if (wr_ready_i)    state_d = S_IDLE;
            default:                       state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        rd_req_o   = 1'b0;
        wr_en_o    = 1'b0;
        cap_set_o  = 1'b0;
        cap_rd_o   = 1'b0;
        ld_set_o   = 1'b0;
        tmr_load_o = 1'b0;
        set_en_o   = 1'b0;
        clr_rst_o  = 1'b0;
        clr_byp_o  = 1'b0;
        unique case (state_q)
            S_IDLE:     cap_set_o = start_i;
            S_FETCH: begin
                rd_req_o = 1'b1;
                cap_rd_o = rd_valid_i;
            end
            S_ARM: begin
                wr_en_o  = 1'b1;
                ld_set_o = wr_ready_i;
            end
            S_LOAD: begin
                wr_en_o    = 1'b1;
                tmr_load_o = wr_ready_i;
            end
            S_SETTLE:   set_en_o = tmr_expired_i;
            S_ENABLE: begin
                wr_en_o   = 1'b1;
                clr_rst_o = wr_ready_i;
            end
            S_UNRESET: begin
                wr_en_o   = 1'b1;
                clr_byp_o = wr_ready_i;
            end
            S_UNBYPASS: wr_en_o = 1'b1;
            default: ;
        endcase
    end

    assign busy_o = (state_q != S_IDLE);
    assign done_o = done_q;

    // R2: a read and a write are never requested together
    assert_rd_wr_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req_o && wr_en_o));

    // R5: timer expiry is only seen while waiting for the loop to settle
    assert_expiry_in_settle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_expired_i |-> (state_q == S_SETTLE));

    // R9: done is a single-cycle pulse, raised only once busy has dropped
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R10: a busy sequence is not restarted by start
    assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && state_q != S_UNBYPASS) |=> busy_o);

endmodule

// File: rtl/pll_reload_seq.sv
module pll_reload_seq
    import pll_seq_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [REG_W-1:0] setting_i,
    output logic             rd_req_o,
    input  logic [REG_W-1:0] rd_data_i,
    input  logic             rd_valid_i,
    output logic             wr_en_o,
    output logic [REG_W-1:0] wr_data_o,
    input  logic             wr_ready_i,
    output logic             busy_o,
    output logic             done_o
);
    localparam int SETTLE_CYC = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;

    logic cap_set, cap_rd, ld_set, tmr_load, set_en, clr_rst, clr_byp;
    logic tmr_expired;

    pll_seq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .rd_valid_i    (rd_valid_i),
        .wr_ready_i    (wr_ready_i),
        .tmr_expired_i (tmr_expired),
        .rd_req_o      (rd_req_o),
        .wr_en_o       (wr_en_o),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .cap_set_o     (cap_set),
        .cap_rd_o      (cap_rd),
        .ld_set_o      (ld_set),
        .tmr_load_o    (tmr_load),
        .set_en_o      (set_en),
        .clr_rst_o     (clr_rst),
        .clr_byp_o     (clr_byp)
    );

    pll_seq_settle_timer #(
        .DELAY (SETTLE_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .expired_o (tmr_expired)
    );

    pll_seq_image u_image (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_set_i (cap_set),
        .setting_i (setting_i),
        .cap_rd_i  (cap_rd),
        .rd_data_i (rd_data_i),
        .ld_set_i  (ld_set),
        .set_en_i  (set_en),
        .clr_rst_i (clr_rst),
        .clr_byp_i (clr_byp),
        .image_o   (wr_data_o)
    );

    // R8: a stalled write keeps its request and data
    assert_wr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && !wr_ready_i) |=> (wr_en_o && $stable(wr_data_o)));

    // R1: nothing is requested while idle
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!rd_req_o && !wr_en_o));

endmodule

// File: tb/pll_reload_seq_bench.sv
module pll_reload_seq_bench;
    localparam int CLK_HZ = 40_000;
    localparam int D      = CLK_HZ / 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] setting_i = '0;
    logic        rd_req_o;
    logic [31:0] rd_data_i;
    logic        rd_valid_i = 1'b0;
    logic        wr_en_o;
    logic [31:0] wr_data_o;
    logic        wr_ready_i = 1'b1;
    logic        busy_o;
    logic        done_o;

    logic [31:0] reg_model = '0;
    logic [31:0] exp_q[$];
    int          vectors = 0;
    int          miscomp = 0;
    int          widx = 0;
    int          rd_cnt = 0;
    int          rd_wait = 0;
    int          gap = 0;
    bit          new_write = 1'b0;
    bit          hold_pend = 1'b0;
    logic [31:0] hold_data = '0;
    bit          stall = 1'b0;
    bit          finished = 1'b0;

    assign rd_data_i = reg_model;

    always #5 clk = ~clk;

    pll_reload_seq #(.CLK_HZ(CLK_HZ)) u_pll_reload_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .setting_i  (setting_i),
        .rd_req_o   (rd_req_o),
        .rd_data_i  (rd_data_i),
        .rd_valid_i (rd_valid_i),
        .wr_en_o    (wr_en_o),
        .wr_data_o  (wr_data_o),
        .wr_ready_i (wr_ready_i),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscomp++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input int i);
        case (i)
            0:       return "R3";
            1:       return "R4";
            2:       return "R6";
            default: return "R7";
        endcase
    endfunction

    // Register-side model: read latency and write back-pressure
    always @(posedge clk) begin
        #1;
        if (rd_req_o) begin
            if (rd_wait == 0) rd_valid_i = 1'b1;
            else begin
                rd_valid_i = 1'b0;
                rd_wait--;
            end
        end else begin
            rd_valid_i = 1'b0;
        end
        wr_ready_i = stall ? ~wr_ready_i : 1'b1;
    end

    // Monitor: pops the scoreboard on every accepted write
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_req_o && rd_valid_i) rd_cnt++;
            if (hold_pend) begin
                chk(wr_en_o && wr_data_o == hold_data, "R8", wr_data_o, hold_data);
                hold_pend = 1'b0;
            end
            if (wr_en_o && new_write) begin
                if (widx > 0)
                    chk(gap == ((widx == 2) ? D : 0), "R5", 32'(gap), 32'((widx == 2) ? D : 0));
                new_write = 1'b0;
            end
            if (wr_en_o && wr_ready_i) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10", wr_data_o, 32'h0);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(wr_data_o == e, tag_of(widx), wr_data_o, e);
                end
                reg_model = wr_data_o;
                widx++;
                new_write = 1'b1;
                gap = 0;
            end else if (wr_en_o) begin
                hold_pend = 1'b1;
                hold_data = wr_data_o;
            end else if (busy_o && widx > 0) begin
                gap++;
            end
        end
    end

    task automatic run_op(input logic [31:0] init, input logic [31:0] set,
                          input bit stall_m, input int rwait, input bit spur);
        logic [31:0] w1, w2, w3, w4, w5;
        bit seen;
        w1 = (init & ~32'h0000_0020) | 32'h8000_0100;
        w2 = w1 | (set & ~32'h8000_0920);
        w3 = w2 | 32'h0000_0800;
        w4 = w3 & ~32'h8000_0000;
        w5 = w4 & ~32'h0000_0100;
        @(posedge clk); #1;
        reg_model = init;
        stall     = stall_m;
        rd_wait   = rwait;
        widx      = 0;
        rd_cnt    = 0;
        exp_q.push_back(w1);
        exp_q.push_back(w2);
        exp_q.push_back(w3);
        exp_q.push_back(w4);
        exp_q.push_back(w5);
        setting_i = set;
        start_i   = 1'b1;
        @(posedge clk); #1;
        start_i   = 1'b0;
        setting_i = ~set;                 // R4: later changes must not matter
        @(negedge clk);
        chk(busy_o, "R9", 32'(busy_o), 32'h1);
        if (spur) begin
            while (widx < 2) begin
                @(posedge clk); #1;
            end
            start_i   = 1'b1;             // R10: start during the settle wait
            setting_i = 32'hDEAD_BEEF;
            @(posedge clk); #1;
            start_i   = 1'b0;
        end
        seen = 1'b0;
        for (int k = 0; k < 5000 && !seen; k++) begin
            @(negedge clk);
            if (done_o) seen = 1'b1;
        end
        chk(seen, "R9", 32'(seen), 32'h1);
        chk(!busy_o, "R9", 32'(busy_o), 32'h0);
        chk(exp_q.size() == 0, "R7", 32'(exp_q.size()), 32'h0);
        chk(rd_cnt == 1, "R2", 32'(rd_cnt), 32'h1);
        @(negedge clk);
        chk(!done_o, "R9", 32'(done_o), 32'h0);
        if (spur) begin
            repeat (6) @(negedge clk);
            chk(!busy_o && widx == 5 && rd_cnt == 1, "R10", 32'(widx), 32'h5);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o && !rd_req_o && !wr_en_o, "R1",
            {28'h0, busy_o, done_o, rd_req_o, wr_en_o}, 32'h0);
        run_op(32'h0000_0000, 32'h1234_5678, 1'b0, 0, 1'b0);
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 3, 1'b0);
        run_op(32'h0000_0820, 32'h0000_0000, 1'b0, 1, 1'b1);
        run_op(32'hA5A5_A5A5, 32'h5A5A_5A5A, 1'b1, 0, 1'b0);
        run_op(32'h7FFF_FEDF, 32'h8000_0920, 1'b0, 2, 1'b0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "R9 watchdog", 32'h0, 32'h1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
            $finish;
        end
    end

endmodule